// File: doc/BRIEF.md
# Max-Log Soft-Output Combiner for an 8-State Recursive Code

This block closes one step of a Max-Log soft-output decoder for an 8-state recursive systematic convolutional code. For one trellis step it takes the forward metric of every state, the four branch metrics of the step and the backward metric of every state one step later. From these it builds the metric of all sixteen branches. It reduces the eight branches that carry input bit 1 and the eight that carry input bit 0 to one maximum each, and returns their difference as the log-likelihood ratio. From that ratio it also forms an extrinsic value and a hard decision.

The datapath is a six-stage pipeline that can accept one step per clock. The input and output sides are valid/ready streams. A step is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While a result is waiting and `out_ready` is low, the whole pipeline freezes, `in_ready` drops, and the presented result stays unchanged. Back-pressure therefore reaches the input in the same cycle, with no skid storage.

Top module: `llr_unit`

## Requirements
- R1: The trellis state s is 3 bits: s[2] is the newest register, s[1] the middle one and s[0] the oldest. For input bit u the feedback is f = u^s[1]^s[0], the parity is p = f^s[2]^s[0] and the next state is {f,s[2],s[1]}. `llr_out` equals the maximum of alpha[s]+gamma[u=1,p]+beta[next] over the eight states, minus the same maximum taken with u=0.
- R2: Metric packing on the ports is as follows. State s of `alpha_in` and `beta_in` sits at bits [s*MW +: MW]. The branch metric for input u and parity p sits in slot 2u+p of `gamma_in`, at bits [(2u+p)*GW +: GW]. All metrics are two's complement.
- R3: With the pipeline empty and `out_ready` held high, `out_valid` rises after the sixth rising edge, counting the accepting edge as the first.
- R4: While `out_valid` is high and `out_ready` is low, `llr_out`, `ext_out` and `hard_out` hold their values and `out_valid` stays high.
- R5: `ext_out` equals `llr_out - sys_in - apri_in`, computed without overflow and saturated to the signed range of XW bits (-128..127 by default). The sideband inputs are taken with the same step.
- R6: `hard_out` is 1 when `llr_out` is greater than zero. It is 0 when `llr_out` is zero or negative.
- R7: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. Results leave in acceptance order, one per accepted step, and no more than six steps are ever in flight.
- R8: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Step data is presented |
| in_ready | output | 1 | Pipeline can take a step this cycle |
| alpha_in | input | 8*MW | Forward metrics of step k, one per state |
| beta_in | input | 8*MW | Backward metrics of step k+1, one per state |
| gamma_in | input | 4*GW | Branch metrics of step k, slot 2u+p |
| sys_in | input | XW | Systematic soft input of the step |
| apri_in | input | XW | A priori soft input of the step |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| llr_out | output | max(MW,GW)+3 | Log-likelihood ratio |
| ext_out | output | XW | Saturated extrinsic value |
| hard_out | output | 1 | Hard decision |

## Verification
The hardest situation to reach from the ports is a stall that arrives while the pipeline holds several steps at different depths. Such a stall has to freeze all of them without loss, and sideband values have to stay aligned with their own metrics. The stimulus reaches it by pulling `out_ready` low at random while steps are offered back to back, and it checks both that the stalled outputs do not move and that every result matches its own step in order. Directed steps put the winning branch in a chosen gamma slot, force equal maxima, and drive the extrinsic value past both saturation limits.

// File: rtl/llr_pkg.sv
package llr_pkg;
  localparam int NSTATE = 8;
  localparam int NSLOT  = 4;

  function automatic logic fb_bit(input logic [2:0] s, input logic u);
    return u ^ s[1] ^ s[0];
  endfunction

  function automatic logic par_bit(input logic [2:0] s, input logic u);
    return fb_bit(s, u) ^ s[2] ^ s[0];
  endfunction

  function automatic logic [2:0] nxt_state(input logic [2:0] s, input logic u);
    return {fb_bit(s, u), s[2], s[1]};
  endfunction
endpackage

// File: rtl/llr_branch_sum.sv
module llr_branch_sum #(
  parameter int MW = 12,
  parameter int GW = 10,
  parameter int SW = 14
) (
  input  logic                              clk,
  input  logic                              en,
  input  logic [llr_pkg::NSTATE*MW-1:0]     alpha_in,
  input  logic [llr_pkg::NSTATE*MW-1:0]     beta_in,
  input  logic [llr_pkg::NSLOT*GW-1:0]      gamma_in,
  output logic [llr_pkg::NSTATE*SW-1:0]     sum0_flat,
  output logic [llr_pkg::NSTATE*SW-1:0]     sum1_flat
);
  import llr_pkg::*;

  logic signed [SW-1:0] ag0 [NSTATE];
  logic signed [SW-1:0] ag1 [NSTATE];
  logic signed [SW-1:0] bq  [NSTATE];
  logic signed [SW-1:0] br0 [NSTATE];
  logic signed [SW-1:0] br1 [NSTATE];

  function automatic logic signed [SW-1:0] st_metric(input logic [NSTATE*MW-1:0] v, input int idx);
    return SW'($signed(v[idx*MW +: MW]));
  endfunction

  function automatic logic signed [SW-1:0] br_metric(input logic [NSLOT*GW-1:0] v, input int idx);
    return SW'($signed(v[idx*GW +: GW]));
  endfunction

  // stage 1: alpha plus the branch metric of each branch; beta registered alongside
  // stage 2: add beta of the state each branch leads to
  always_ff @(posedge clk) begin
    if (en) begin
      for (int s = 0; s < NSTATE; s++) begin
        ag0[s] <= st_metric(alpha_in, s) + br_metric(gamma_in, int'(par_bit(3'(s), 1'b0)));
        ag1[s] <= st_metric(alpha_in, s) + br_metric(gamma_in, 2 + int'(par_bit(3'(s), 1'b1)));
        bq[s]  <= st_metric(beta_in, s);
      end
      for (int s = 0; s < NSTATE; s++) begin
        br0[s] <= ag0[s] + bq[nxt_state(3'(s), 1'b0)];
        br1[s] <= ag1[s] + bq[nxt_state(3'(s), 1'b1)];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NSTATE; s++) begin
      sum0_flat[s*SW +: SW] = br0[s];
      sum1_flat[s*SW +: SW] = br1[s];
    end
  end
endmodule

// File: rtl/llr_max_tree.sv
module llr_max_tree #(
  parameter int N = 8,
  parameter int W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [N*W-1:0]      in_flat,
  output logic signed [W-1:0] out_max
);
  localparam int LV = $clog2(N);

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int CNT = N >> (l + 1);
    for (genvar i = 0; i < CNT; i++) begin : g_node
      logic signed [W-1:0] x;
      logic signed [W-1:0] y;
      logic signed [W-1:0] q;
      if (l == 0) begin : g_leaf
        assign x = in_flat[(2*i)*W +: W];
        assign y = in_flat[(2*i+1)*W +: W];
      end else begin : g_inner
        assign x = g_lvl[l-1].g_node[2*i].q;
        assign y = g_lvl[l-1].g_node[2*i+1].q;
      end
      always_ff @(posedge clk) begin
        if (en) q <= (x > y) ? x : y;
      end
    end
  end

  assign out_max = g_lvl[LV-1].g_node[0].q;

  // cycles since reset, saturating, so the bound below never looks before reset
  logic [7:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm < 8'(LV)) warm <= warm + 8'd1;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R1: the reduced value is never below any branch that entered LV advancing cycles ago
    a_r1_tree_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 8'(LV)) && $past(en, 1) && $past(en, 2) && $past(en, 3)
      |-> out_max >= $signed($past(in_flat[i*W +: W], LV)));
  end
endmodule

// File: rtl/llr_result.sv
module llr_result #(
  parameter int SW = 14,
  parameter int LW = 15,
  parameter int XW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] max1,
  input  logic signed [SW-1:0] max0,
  input  logic signed [XW-1:0] sys_v,
  input  logic signed [XW-1:0] apri_v,
  output logic                 out_valid,
  output logic signed [LW-1:0] llr_q,
  output logic signed [XW-1:0] ext_q,
  output logic                 hard_q
);
  localparam int EW = LW + 2;
  localparam logic signed [EW-1:0] XMAX = EW'((2 ** (XW - 1)) - 1);
  localparam logic signed [EW-1:0] XMIN = -XMAX - EW'(1);

  logic signed [LW-1:0] diff;
  logic signed [EW-1:0] wide;
  logic signed [XW-1:0] sat;

  always_comb begin
    diff = LW'(max1) - LW'(max0);
    wide = EW'(diff) - EW'(sys_v) - EW'(apri_v);
    if (wide > XMAX)      sat = XMAX[XW-1:0];
    else if (wide < XMIN) sat = XMIN[XW-1:0];
    else                  sat = wide[XW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (en) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      llr_q  <= diff;
      ext_q  <= sat;
      hard_q <= diff > 0;
    end
  end

  // R6: decision follows which reduced maximum was larger one stage earlier
  a_r6_hard_sign: assert property (@(posedge clk) disable iff (!rst_n)
    en && in_valid |=> hard_q == ($past(max1) > $past(max0)));

  // R5: equal maxima and zero sideband give zero ratio and zero extrinsic
  a_r5_zero_prior: assert property (@(posedge clk) disable iff (!rst_n)
    en && in_valid && sys_v == 0 && apri_v == 0 && max1 == max0
    |=> llr_q == 0 && ext_q == 0 && !hard_q);
endmodule

// File: rtl/llr_unit.sv
module llr_unit #(
  parameter int MW = 12,
  parameter int GW = 10,
  parameter int XW = 8,
  localparam int SW = ((MW > GW) ? MW : GW) + 2,
  localparam int LW = SW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [8*MW-1:0]       alpha_in,
  input  logic [8*MW-1:0]       beta_in,
  input  logic [4*GW-1:0]       gamma_in,
  input  logic [XW-1:0]         sys_in,
  input  logic [XW-1:0]         apri_in,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LW-1:0]         llr_out,
  output logic [XW-1:0]         ext_out,
  output logic                  hard_out
);
  import llr_pkg::*;

  localparam int PRE = 2 + $clog2(NSTATE);   // stages ahead of the result register
  localparam int DEPTH = PRE + 1;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic [NSTATE*SW-1:0] sum0_flat, sum1_flat;
  logic signed [SW-1:0] max0, max1;

  llr_branch_sum #(.MW(MW), .GW(GW), .SW(SW)) u_branch (
    .clk(clk), .en(adv), .alpha_in(alpha_in), .beta_in(beta_in), .gamma_in(gamma_in),
    .sum0_flat(sum0_flat), .sum1_flat(sum1_flat)
  );

  llr_max_tree #(.N(NSTATE), .W(SW)) u_tree1 (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_flat(sum1_flat), .out_max(max1)
  );

  llr_max_tree #(.N(NSTATE), .W(SW)) u_tree0 (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_flat(sum0_flat), .out_max(max0)
  );

  // valid and sideband travel with the metrics
  logic [PRE-1:0] vld;
  logic [XW-1:0]  sys_d  [PRE];
  logic [XW-1:0]  apri_d [PRE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (adv) vld <= {vld[PRE-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      sys_d[0]  <= sys_in;
      apri_d[0] <= apri_in;
      for (int k = 1; k < PRE; k++) begin
        sys_d[k]  <= sys_d[k-1];
        apri_d[k] <= apri_d[k-1];
      end
    end
  end

  logic signed [LW-1:0] llr_q;
  logic signed [XW-1:0] ext_q;

  llr_result #(.SW(SW), .LW(LW), .XW(XW)) u_result (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(vld[PRE-1]),
    .max1(max1), .max0(max0),
    .sys_v($signed(sys_d[PRE-1])), .apri_v($signed(apri_d[PRE-1])),
    .out_valid(out_valid), .llr_q(llr_q), .ext_q(ext_q), .hard_q(hard_out)
  );

  assign llr_out = llr_q;
  assign ext_out = ext_q;

  // R4: a refused result is held unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(llr_out) && $stable(ext_out) && $stable(hard_out));

  // R7: accepted minus delivered never exceeds the pipeline depth
  logic [7:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
  end

  a_r7_inflight: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(DEPTH));
endmodule

// File: tb/llr_unit_test.sv
module llr_unit_test;
  localparam int MW = 12;
  localparam int GW = 10;
  localparam int XW = 8;
  localparam int SW = 14;
  localparam int LW = 15;
  localparam int NMAX = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [8*MW-1:0] alpha_in = '0;
  logic [8*MW-1:0] beta_in = '0;
  logic [4*GW-1:0] gamma_in = '0;
  logic [XW-1:0] sys_in = '0;
  logic [XW-1:0] apri_in = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [LW-1:0] llr_out;
  logic [XW-1:0] ext_out;
  logic hard_out;

  always #10 clk = ~clk;

  llr_unit #(.MW(MW), .GW(GW), .XW(XW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .alpha_in(alpha_in), .beta_in(beta_in), .gamma_in(gamma_in),
    .sys_in(sys_in), .apri_in(apri_in), .out_valid(out_valid), .out_ready(out_ready),
    .llr_out(llr_out), .ext_out(ext_out), .hard_out(hard_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int exp_llr [NMAX];
  int exp_ext [NMAX];
  int exp_hrd [NMAX];
  int exp_cyc [NMAX];
  int wr = 0;
  int rd = 0;
  int rmode = 0;      // 0: always ready, 1: random ready
  logic strict = 1'b1;

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // independent trellis model
  function automatic int nstate(input int s, input int u);
    int f;
    f = u ^ ((s >> 1) & 1) ^ (s & 1);
    return (f << 2) | (s >> 1);
  endfunction
  function automatic int parity(input int s, input int u);
    int f;
    f = u ^ ((s >> 1) & 1) ^ (s & 1);
    return f ^ ((s >> 2) & 1) ^ (s & 1);
  endfunction

  function automatic int model_llr(input logic [8*MW-1:0] a, input logic [8*MW-1:0] b,
                                   input logic [4*GW-1:0] g);
    int m [2];
    for (int u = 0; u < 2; u++) begin
      m[u] = -1000000;
      for (int s = 0; s < 8; s++) begin
        int v;
        v = int'($signed(a[s*MW +: MW])) + int'($signed(g[(2*u + parity(s, u))*GW +: GW]))
          + int'($signed(b[nstate(s, u)*MW +: MW]));
        if (v > m[u]) m[u] = v;
      end
    end
    return m[1] - m[0];
  endfunction

  function automatic int model_ext(input int l, input logic [XW-1:0] sy, input logic [XW-1:0] ap);
    int e;
    e = l - int'($signed(sy)) - int'($signed(ap));
    if (e > 127) e = 127;
    if (e < -128) e = -128;
    return e;
  endfunction

  task automatic send(input logic [8*MW-1:0] a, input logic [8*MW-1:0] b,
                      input logic [4*GW-1:0] g, input logic [XW-1:0] sy, input logic [XW-1:0] ap);
    int l;
    @(negedge clk);
    in_valid = 1'b1; alpha_in = a; beta_in = b; gamma_in = g; sys_in = sy; apri_in = ap;
    #2;
    while (!in_ready) begin
      if (rmode == 0) check(1'b0, "R7 ready while consumer ready", 0, 1);
      @(negedge clk); #2;
    end
    l = model_llr(a, b, g);
    exp_llr[wr] = l;
    exp_ext[wr] = model_ext(l, sy, ap);
    exp_hrd[wr] = (l > 0) ? 1 : 0;
    exp_cyc[wr] = cyc;
    wr++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // result monitor
  initial begin
    logic prev_stall;
    logic [LW-1:0] s_llr;
    logic [XW-1:0] s_ext;
    logic s_hrd;
    prev_stall = 1'b0; s_llr = '0; s_ext = '0; s_hrd = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = (rmode == 0) ? 1'b1 : (($urandom % 10) < 6);
      #1;
      if (prev_stall) begin
        check(out_valid && llr_out == s_llr && ext_out == s_ext && hard_out == s_hrd,
              "R4 hold during stall", int'($signed(llr_out)), int'($signed(s_llr)));
      end
      if (out_valid && out_ready) begin
        if (rd >= wr) check(1'b0, "R7 result without step", rd, wr);
        else begin
          check(int'($signed(llr_out)) == exp_llr[rd], "R1 llr", int'($signed(llr_out)), exp_llr[rd]);
          check(int'($signed(ext_out)) == exp_ext[rd], "R5 extrinsic", int'($signed(ext_out)), exp_ext[rd]);
          check(int'(hard_out) == exp_hrd[rd], "R6 hard decision", int'(hard_out), exp_hrd[rd]);
          if (rd == 0 && strict)
            check(cyc - exp_cyc[rd] == 6, "R3 latency", cyc - exp_cyc[rd], 6);
          rd++;
        end
      end
      prev_stall = out_valid && !out_ready;
      s_llr = llr_out; s_ext = ext_out; s_hrd = hard_out;
    end
  end

  // watchdog
  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", rd, wr);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [8*MW-1:0] st_fill(input int v);
    logic [8*MW-1:0] r;
    for (int s = 0; s < 8; s++) r[s*MW +: MW] = MW'(v);
    return r;
  endfunction

  initial begin
    logic [8*MW-1:0] a, b;
    logic [4*GW-1:0] g;
    void'($urandom(32'd4242));
    #45;
    @(negedge clk); #3;
    check(!out_valid, "R8 out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R8 in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 first step alone, R5/R6 zero tie
    send('0, '0, '0, '0, '0);
    idle();
    repeat (8) @(negedge clk);

    // R2: only slot u=1 carries metric -> llr 300, ext 150
    g = '0; g[2*GW +: GW] = 10'sd300; g[3*GW +: GW] = 10'sd300;
    send('0, '0, g, 8'sd100, 8'sd50);
    // R2: only slot u=0,p=1 set -> llr -500
    g = '0; g[1*GW +: GW] = 10'sd500;
    send('0, '0, g, '0, '0);
    // R5 positive saturation
    a = st_fill(0); b = st_fill(0); g = '0;
    g[2*GW +: GW] = 10'sd511; g[3*GW +: GW] = 10'sd511;
    send(a, b, g, 8'h80, 8'h80);
    // R5 negative saturation
    g = '0; g[0 +: GW] = 10'sd511; g[1*GW +: GW] = 10'sd511;
    send(a, b, g, 8'h7f, 8'h7f);
    // R1 beta steering: single large beta on state 4
    b = st_fill(-2000); b[4*MW +: MW] = 12'sd2000;
    send(st_fill(0), b, '0, '0, '0);
    // R1 extreme metrics
    send(st_fill(2047), st_fill(-2048), '0, 8'sd3, 8'sd4);
    // R7 back to back with consumer always ready
    for (int n = 0; n < 40; n++) begin
      for (int s = 0; s < 8; s++) begin
        a[s*MW +: MW] = MW'($urandom); b[s*MW +: MW] = MW'($urandom);
      end
      for (int k = 0; k < 4; k++) g[k*GW +: GW] = GW'($urandom);
      send(a, b, g, XW'($urandom), XW'($urandom));
    end
    idle();
    repeat (10) @(negedge clk);

    // random back-pressure with bursts and gaps
    rmode = 1;
    for (int n = 0; n < 400; n++) begin
      for (int s = 0; s < 8; s++) begin
        a[s*MW +: MW] = MW'(int'($urandom % 1024) - 512);
        b[s*MW +: MW] = MW'(int'($urandom % 1024) - 512);
      end
      for (int k = 0; k < 4; k++) g[k*GW +: GW] = GW'(int'($urandom % 256) - 128);
      send(a, b, g, XW'($urandom), XW'($urandom));
      if (($urandom % 5) == 0) begin
        idle();
        repeat ($urandom % 4) @(negedge clk);
      end
    end
    idle();
    rmode = 0;
    repeat (20) @(negedge clk);
    check(rd == wr, "R7 every step delivered", rd, wr);
    check(!out_valid, "R7 pipeline drained", int'(out_valid), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule